// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Controller

This block decides, cycle by cycle, whether a new task may be launched into a static multi-stage pipeline whose stages are reused at fixed offsets. It avoids stage conflicts by keeping a collision state register. The register is built from a parameterised initial collision vector. That vector lists the forbidden launch latencies.

A request that arrives in a forbidden cycle is held inside the block. It is launched at the first cycle that is free, so the controller always takes the earliest legal latency (greedy scheduling). Two counters run alongside the state: one counts launches and one counts enabled cycles. Their ratio gives the achieved throughput.

Top module: `cv_init_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `accept` is 0 and `state`, `init_count` and `cycle_count` are all 0.
- R2: `accept` is 1 in a cycle exactly when `en` is 1, a task is wanted (`req` is 1 or a request is held), and bit 0 of `state` is 0. Bit k of `state` (LSB = bit 0) is 1 when a launch k cycles after the current one is forbidden.
- R3: At every clock edge `state` becomes its old value shifted right by one with 0 entering the top bit. When `accept` was 1, that shifted value is ORed with `ICV`.
- R4: Bit i-1 of the parameter `ICV` (width `W`, at most 8) is 1 when launch latency i is forbidden. Two tasks are never accepted at a forbidden distance from each other.
- R5: A `req` seen in a cycle without `accept` is held and accepted at the first cycle in which `en` is 1 and `state[0]` is 0. Further requests while one is held add no extra launch.
- R6: While `en` is 0, no task is accepted and both counters hold. `state` still shifts, and a held request is kept.
- R7: `init_count` rises by one per accepted task. `cycle_count` rises by one per cycle with `en` at 1.
- R8: With `ICV` = 5'b10011 (forbidden 1, 2, 5) and `req` held high from the idle state, launches settle at latency 3. That gives 8 launches in the first 24 enabled cycles.
- R9: With `ICV` = 6'b101010 (forbidden 2, 4, 6) and `req` held high from the idle state, launch latencies alternate 1, 7. That gives 6 launches in 24 enabled cycles.
- R10: When `state` is all zero, a request with `en` at 1 is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; gates launches and counters |
| req | input | 1 | Task request |
| accept | output | 1 | Task launched this cycle |
| state | output | W | Current collision state |
| init_count | output | CNT_W | Number of accepted tasks |
| cycle_count | output | CNT_W | Number of enabled cycles |

## Verification
Each of the two example vectors gets a request held high from idle. This separates a true greedy schedule (latency 3 for one vector, 1/7 for the other) from one that waits for full drain or skips a bit. Single-cycle request pulses that fall in forbidden cycles show whether a request is held and whether duplicate pulses merge. A run with enable low shows whether the state keeps draining while launches and counters freeze. Long random mixes of request and enable, compared cycle by cycle with a bench model of the shift-and-OR rule, expose off-by-one shifting and wrong OR timing.

// File: rtl/cv_init_ctrl.sv
module cv_init_ctrl #(
  parameter int W = 5,
  parameter logic [W-1:0] ICV = 5'b10011,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             req,
  output logic             accept,
  output logic [W-1:0]     state,
  output logic [CNT_W-1:0] init_count,
  output logic [CNT_W-1:0] cycle_count
);

  logic [W-1:0]     cs;
  logic             held;
  logic [CNT_W-1:0] n_init;
  logic [CNT_W-1:0] n_cyc;

  wire want = req | held;

  assign accept      = en & want & ~cs[0];
  assign state       = cs;
  assign init_count  = n_init;
  assign cycle_count = n_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs     <= '0;
      held   <= 1'b0;
      n_init <= '0;
      n_cyc  <= '0;
    end else begin
      cs   <= (cs >> 1) | (accept ? ICV : '0);
      held <= want & ~accept;
      if (accept) n_init <= n_init + 1'b1;
      if (en)     n_cyc  <= n_cyc + 1'b1;
    end
  end

endmodule

// File: rtl/cv_init_ctrl_chk.sv
module cv_init_ctrl_chk #(
  parameter int W = 5,
  parameter logic [W-1:0] ICV = 5'b10011,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             req,
  input logic             accept,
  input logic [W-1:0]     state,
  input logic [CNT_W-1:0] init_count,
  input logic [CNT_W-1:0] cycle_count
);

  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> state == ($past(state) >> 1)); // R3

  AST_LOAD_ICV: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state & ICV) == ICV); // R3

  AST_NO_LAT1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !(accept && ICV[0])); // R4

  AST_INIT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> init_count == CNT_W'($past(init_count) + 1'b1)); // R7

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> init_count == $past(init_count) && cycle_count == $past(cycle_count)); // R6

  AST_IDLE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req && state == '0) |-> accept); // R10

endmodule

bind cv_init_ctrl cv_init_ctrl_chk #(.W(W), .ICV(ICV), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/cv_init_ctrl_test.sv
`timescale 1ns/1ps
module cv_init_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic en_a = 0, req_a = 0, en_b = 0, req_b = 0;
  logic acc_a, acc_b;
  logic [4:0] st_a;
  logic [5:0] st_b;
  logic [15:0] ic_a, cc_a, ic_b, cc_b;
  int nchk = 0, nerr = 0;

  logic [7:0] ma_cs, mb_cs;
  logic ma_p, mb_p;
  int ma_ic, ma_cc, mb_ic, mb_cc;
  logic last_a, last_b;

  localparam logic [7:0] ICV_A = 8'b0001_0011;
  localparam logic [7:0] ICV_B = 8'b0010_1010;

  always #10 clk = ~clk;

  cv_init_ctrl uut (.clk(clk), .rst_n(rst_n), .en(en_a), .req(req_a), .accept(acc_a),
    .state(st_a), .init_count(ic_a), .cycle_count(cc_a));
  cv_init_ctrl #(.W(6), .ICV(6'b101010)) uut_b (.clk(clk), .rst_n(rst_n), .en(en_b), .req(req_b),
    .accept(acc_b), .state(st_b), .init_count(ic_b), .cycle_count(cc_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic macc(input logic [7:0] cs, input logic p, input logic r, input logic e);
    return e & (r | p) & ~cs[0];
  endfunction

  task automatic tick();
    logic xa, xb;
    #2;
    xa = macc(ma_cs, ma_p, req_a, en_a);
    xb = macc(mb_cs, mb_p, req_b, en_b);
    chk(acc_a == xa, "R2 accept A", acc_a, xa);
    chk(acc_b == xb, "R2 accept B", acc_b, xb);
    chk(st_a == ma_cs[4:0], "R3 state A", st_a, ma_cs);
    chk(st_b == mb_cs[5:0], "R3 state B", st_b, mb_cs);
    chk(ic_a == ma_ic[15:0] && ic_b == mb_ic[15:0], "R7 init_count", ic_a, ma_ic);
    chk(cc_a == ma_cc[15:0] && cc_b == mb_cc[15:0], "R7 cycle_count", cc_a, ma_cc);
    last_a = acc_a; last_b = acc_b;
    ma_p = (req_a | ma_p) & ~xa;
    mb_p = (req_b | mb_p) & ~xb;
    ma_cs = (ma_cs >> 1) | (xa ? ICV_A : 8'h0);
    mb_cs = (mb_cs >> 1) | (xb ? ICV_B : 8'h0);
    ma_ic += int'(xa); mb_ic += int'(xb);
    ma_cc += int'(en_a); mb_cc += int'(en_b);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; req_a = 0; req_b = 0; en_a = 0; en_b = 0;
    @(negedge clk); @(negedge clk); #2;
    chk(acc_a == 0 && st_a == 0 && ic_a == 0 && cc_a == 0, "R1 reset A", st_a, 0);
    chk(acc_b == 0 && st_b == 0 && ic_b == 0 && cc_b == 0, "R1 reset B", st_b, 0);
    ma_cs = 0; mb_cs = 0; ma_p = 0; mb_p = 0;
    ma_ic = 0; ma_cc = 0; mb_ic = 0; mb_cc = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20ns * 200000);
    nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int bad_a, bad_b;
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R8 / R9: greedy cycles from idle with request held high
    en_a = 1; en_b = 1; req_a = 1; req_b = 1;
    bad_a = 0; bad_b = 0;
    for (int i = 0; i < 24; i++) begin
      tick();
      if (last_a != ((i % 3) == 0)) bad_a++;
      if (last_b != ((i % 8) < 2)) bad_b++;
    end
    chk(bad_a == 0, "R8 latency-3 pattern mismatches", bad_a, 0);
    chk(bad_b == 0, "R9 latency 1/7 pattern mismatches", bad_b, 0);
    #1;
    chk(ic_a == 8, "R8 launches in 24 cycles", ic_a, 8);
    chk(ic_b == 6, "R9 launches in 24 cycles", ic_b, 6);
    chk(cc_a == 24 && cc_b == 24, "R7 cycles counted", cc_a, 24);

    // R10: drain then immediate grant
    req_a = 0; req_b = 0;
    for (int i = 0; i < 10; i++) tick();
    #1;
    chk(st_a == 0 && st_b == 0, "R10 drained state", st_b, 0);
    req_a = 1; req_b = 1;
    tick();
    chk(last_a && last_b, "R10 grant on empty state", last_a, 1);

    // R5: held request, merged duplicates
    do_reset();
    en_a = 1; en_b = 1; req_a = 1; req_b = 1;
    tick();
    req_b = 0; req_a = 1;
    tick();                       // A t1 forbidden, held
    req_b = 1;
    tick();                       // A t2 forbidden, duplicate; B t2 forbidden
    chk(!last_a && !last_b, "R5 no grant in forbidden cycle", last_b, 0);
    req_a = 0; req_b = 0;
    tick();                       // t3: both free
    chk(last_a && last_b, "R5 held request granted", last_b, 1);
    for (int i = 0; i < 10; i++) tick();
    #1;
    chk(ic_a == 2, "R5 duplicates merged A", ic_a, 2);
    chk(ic_b == 2, "R5 held request B count", ic_b, 2);

    // R6: enable low freezes launches and counters but drains state
    do_reset();
    en_b = 1; req_b = 1;
    tick();
    en_b = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk(!last_b, "R6 no grant while disabled", last_b, 0);
    end
    #1;
    chk(st_b == 0, "R6 state drained while disabled", st_b, 0);
    chk(ic_b == 1 && cc_b == 1, "R6 counters held", cc_b, 1);
    en_b = 1; req_b = 0;
    tick();
    chk(last_b, "R6 held request granted on enable", last_b, 1);

    // R4 and all rules: random mix against the model
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      req_a = ($urandom % 10) < 3; en_a = ($urandom % 10) < 9;
      req_b = ($urandom % 10) < 4; en_b = ($urandom % 10) < 9;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule